// File: doc/BRIEF.md
# I2C Bus Line Conditioner

This block sits between the two raw wires of an I2C bus and the protocol logic of a target that runs on a much faster system clock. Each wire is brought into the clock domain through a short flop chain and then passed through a spike filter. The filtered levels drive a small event detector that emits one-cycle strobes for SCL rising and falling edges, start conditions and stop conditions, plus a level that shows when the bus is idle.

The filter threshold is given in system-clock cycles and comes from two run-time inputs: one value for standard-speed buses and one for fast buses. A mode input picks between them. At 100 MHz, values of 10 and 5 cycles reject spikes shorter than 100 ns and 50 ns.

On the transmit side, the byte logic presents the SDA level it wants on `tx_sda`. The block applies that level to the open-drain pull-down only while the filtered SCL is low, and only after a fixed number of cycles has passed since SCL fell. This keeps the target's own data changes clear of the uncertain SCL fall time, so they are never seen on the bus as a start or a stop.

Top module: `i2c_line_cond`

## Requirements
- R1: While reset is held, and just after it is released with both wires high, `scl_lvl`, `sda_lvl` and `bus_idle` are 1, all four strobes are 0 and `sda_drive_low` is 0.
- R2: A filtered level takes a new value only after its raw wire has held that value for the selected threshold of consecutive samples. A pulse one sample shorter is rejected. This applies to both wires.
- R3: `fast_mode` = 1 selects `filt_fast_cyc` as the threshold and `fast_mode` = 0 selects `filt_std_cyc`. A threshold of 0 acts as 1.
- R4: When filtered SDA falls while filtered SCL is high in both this cycle and the previous one, `start_det` pulses for one cycle.
- R5: When filtered SDA rises while filtered SCL is high in both this cycle and the previous one, `stop_det` pulses for one cycle.
- R6: `scl_rise` and `scl_fall` pulse for exactly one cycle on each change of the filtered SCL level.
- R7: An SCL edge strobe and a start or stop strobe are never high in the same cycle. An SDA change that reaches the filtered side in the same cycle as an SCL edge produces neither a start nor a stop.
- R8: `bus_idle` is 1 exactly when both filtered levels are 1.
- R9: `sda_drive_low` (1 = pull SDA low) takes the value `!tx_sda` only while filtered SCL is low. When a request is pending, the new value first appears in the cycle HOLD_CYC+2 after the cycle that carries `scl_fall`, and never earlier.
- R10: While filtered SCL is high, `sda_drive_low` keeps its value whatever `tx_sda` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| fast_mode | input | 1 | 1 selects the fast-bus filter threshold |
| filt_std_cyc | input | FILT_W | Filter threshold in cycles, standard bus |
| filt_fast_cyc | input | FILT_W | Filter threshold in cycles, fast bus |
| tx_sda | input | 1 | SDA level requested by the transmitter (1 = release) |
| scl_lvl | output | 1 | Filtered SCL level |
| sda_lvl | output | 1 | Filtered SDA level |
| scl_rise | output | 1 | One-cycle strobe on filtered SCL rising |
| scl_fall | output | 1 | One-cycle strobe on filtered SCL falling |
| start_det | output | 1 | One-cycle start condition strobe |
| stop_det | output | 1 | One-cycle stop condition strobe |
| bus_idle | output | 1 | Both filtered lines high |
| sda_drive_low | output | 1 | Enable for the open-drain SDA pull-down |

## Verification
The assertions assume that the threshold inputs and `fast_mode` change only while both wires have been stable for longer than the threshold. They also assume that `tx_sda` is a plain level with no required timing. The stimulus follows these rules: it changes the mode only between settled segments, and it holds every intended wire level for several cycles longer than the current threshold. Spikes are drawn strictly shorter than the threshold, so the intended levels alone predict every edge, start and stop. The hold window is measured on the ports, from the `scl_fall` strobe to the change on `sda_drive_low`.

// File: rtl/i2c_lc_pkg.sv
package i2c_lc_pkg;

    localparam int LC_NUM_LINES = 2;
    localparam int LC_SCL_IDX   = 0;
    localparam int LC_SDA_IDX   = 1;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } lc_evt_t;

endpackage

// File: rtl/i2c_lc_sync.sv
module i2c_lc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SW-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {SW{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[SW-1];
endmodule

// File: rtl/i2c_lc_filter.sv
module i2c_lc_filter #(
    parameter int   CW      = 6,
    parameter logic RST_VAL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_lvl,
    input  logic [CW-1:0] thr,
    output logic          filt_lvl
);
    localparam int CW1 = CW + 1;

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t       st_d, st_q;
    logic [CW-1:0] thr_eff;

    always_comb begin
        st_d    = st_q;
        thr_eff = (thr == '0) ? CW'(1) : thr;
        if (in_lvl == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (({1'b0, st_q.cnt} + CW1'(1)) >= {1'b0, thr_eff}) begin
            st_d.lvl = in_lvl;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: RST_VAL, cnt: '0};
        else        st_q <= st_d;
    end

    assign filt_lvl = st_q.lvl;

    // R2: a flip on the filtered side always follows the synchronised input
    assert_filt_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> ($past(in_lvl) == st_q.lvl));
endmodule

// File: rtl/i2c_lc_detect.sv
module i2c_lc_detect
    import i2c_lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_idle
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } det_st_t;

    det_st_t st_d, st_q;
    lc_evt_t evt;
    logic    scl_held;

    always_comb begin
        st_d.scl_p = scl_lvl;
        st_d.sda_p = sda_lvl;
        scl_held   = scl_lvl & st_q.scl_p;
        evt.rise   = scl_lvl & ~st_q.scl_p;
        evt.fall   = ~scl_lvl & st_q.scl_p;
        evt.start  = scl_held & st_q.sda_p & ~sda_lvl;
        evt.stop   = scl_held & ~st_q.sda_p & sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        else        st_q <= st_d;
    end

    assign scl_rise  = evt.rise;
    assign scl_fall  = evt.fall;
    assign start_det = evt.start;
    assign stop_det  = evt.stop;
    assign bus_idle  = scl_lvl & sda_lvl;

    // R7: edge strobes and condition strobes are mutually exclusive
    assert_edge_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((scl_rise || scl_fall) && (start_det || stop_det)));

    // R6: edge strobes last one cycle
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise);
    assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> !scl_fall);
endmodule

// File: rtl/i2c_lc_sda_hold.sv
module i2c_lc_sda_hold #(
    parameter int HOLD_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic scl_fall,
    input  logic tx_sda,
    output logic sda_drive_low
);
    localparam int              HW     = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0]   HOLD_V = HW'(HOLD_CYC);

    typedef struct packed {
        logic          drv;
        logic [HW-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (scl_fall)              st_d.cnt = HOLD_V;
        else if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - HW'(1);
        if (!scl_lvl && !scl_fall && (st_q.cnt == '0))
            st_d.drv = ~tx_sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{drv: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end

    assign sda_drive_low = st_q.drv;

    // checker: cycles since the last SCL fall, saturating
    localparam int             SFW    = $clog2(HOLD_CYC + 3) + 1;
    localparam logic [SFW-1:0] SF_SAT = SFW'(HOLD_CYC + 2);
    logic [SFW-1:0] sf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sf_q <= SF_SAT;
        else if (scl_fall)    sf_q <= '0;
        else if (sf_q < SF_SAT) sf_q <= sf_q + SFW'(1);
    end

    // R9: output never changes inside the hold window
    assert_hold_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drv != $past(st_q.drv)) |-> (sf_q >= SFW'(HOLD_CYC + 1)));

    // R10: output only updated from a cycle where SCL was low
    assert_hold_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drv != $past(st_q.drv)) |-> !$past(scl_lvl));
endmodule

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import i2c_lc_pkg::*;
#(
    parameter int FILT_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              fast_mode,
    input  logic [FILT_W-1:0] filt_std_cyc,
    input  logic [FILT_W-1:0] filt_fast_cyc,
    input  logic              tx_sda,
    output logic              scl_lvl,
    output logic              sda_lvl,
    output logic              scl_rise,
    output logic              scl_fall,
    output logic              start_det,
    output logic              stop_det,
    output logic              bus_idle,
    output logic              sda_drive_low
);
    logic [LC_NUM_LINES-1:0] raw_w, sync_w, lvl_w;
    logic [FILT_W-1:0]       thr_sel;

    assign raw_w[LC_SCL_IDX] = scl_in;
    assign raw_w[LC_SDA_IDX] = sda_in;
    assign thr_sel = fast_mode ? filt_fast_cyc : filt_std_cyc;

    for (genvar g = 0; g < LC_NUM_LINES; g++) begin : g_line
        i2c_lc_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
        ) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (raw_w[g]),
            .q_out (sync_w[g])
        );

        i2c_lc_filter #(
            .CW      (FILT_W),
            .RST_VAL (1'b1)
        ) filt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_lvl   (sync_w[g]),
            .thr      (thr_sel),
            .filt_lvl (lvl_w[g])
        );
    end

    assign scl_lvl = lvl_w[LC_SCL_IDX];
    assign sda_lvl = lvl_w[LC_SDA_IDX];

    i2c_lc_detect det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_idle  (bus_idle)
    );

    i2c_lc_sda_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) hold_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_lvl       (scl_lvl),
        .scl_fall      (scl_fall),
        .tx_sda        (tx_sda),
        .sda_drive_low (sda_drive_low)
    );

    // R4: a start is only reported with SCL held high across the SDA fall
    assert_start_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |-> (scl_lvl && $past(scl_lvl) && !sda_lvl));

    // R5: same for a stop
    assert_stop_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |-> (scl_lvl && $past(scl_lvl) && sda_lvl));

    // R8: a stop leaves the bus idle
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |-> bus_idle);
endmodule

// File: tb/i2c_line_cond_tb_top.sv
module i2c_line_cond_tb_top;
    localparam int FILT_W   = 6;
    localparam int HOLD_CYC = 30;
    localparam int STD_T    = 10;
    localparam int FAST_T   = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic scl_in, sda_in, fast_mode, tx_sda;
    logic [FILT_W-1:0] filt_std_cyc, filt_fast_cyc;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det, bus_idle, sda_drive_low;

    always #5 clk = ~clk;

    i2c_line_cond #(.FILT_W(FILT_W), .SYNC_STAGES(2), .HOLD_CYC(HOLD_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .fast_mode(fast_mode), .filt_std_cyc(filt_std_cyc), .filt_fast_cyc(filt_fast_cyc),
        .tx_sda(tx_sda), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .bus_idle(bus_idle), .sda_drive_low(sda_drive_low)
    );

    int n_chk = 0, n_fail = 0;
    int mon_start = 0, mon_stop = 0, mon_rise = 0, mon_fall = 0;
    int exp_start = 0, exp_stop = 0, exp_rise = 0, exp_fall = 0;
    int width_err = 0, excl_err = 0;
    int cyc = 0, fall_cyc = 0, last_delay = 0, n_oe_chg = 0;
    logic p_rise = 0, p_fall = 0, p_start = 0, p_stop = 0, p_oe = 0, p_scl = 1;
    logic m_scl = 1, m_sda = 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (scl_rise)  mon_rise++;
            if (scl_fall)  mon_fall++;
            if (start_det) mon_start++;
            if (stop_det)  mon_stop++;
            if ((scl_rise && p_rise) || (scl_fall && p_fall) ||
                (start_det && p_start) || (stop_det && p_stop)) width_err++;
            if ((scl_rise || scl_fall) && (start_det || stop_det)) excl_err++;
            if (scl_fall) fall_cyc = cyc;
            if (sda_drive_low != p_oe) begin
                last_delay = cyc - fall_cyc;
                n_oe_chg++;
                check((p_scl == 1'b0) && (last_delay >= HOLD_CYC + 2),
                      "R9 output change window", last_delay, HOLD_CYC + 2);
            end
        end
        p_rise = scl_rise; p_fall = scl_fall; p_start = start_det; p_stop = stop_det;
        p_oe = sda_drive_low; p_scl = scl_lvl;
    end

    function automatic int thr_now();
        int t;
        t = fast_mode ? int'(filt_fast_cyc) : int'(filt_std_cyc);
        return (t == 0) ? 1 : t;
    endfunction

    // reference model of the conditions from the intended levels
    task automatic move(input logic ns, input logic nd, input int hold);
        @(negedge clk);
        if (m_scl && ns && m_sda && !nd) exp_start++;
        if (m_scl && ns && !m_sda && nd) exp_stop++;
        if (!m_scl && ns) exp_rise++;
        if (m_scl && !ns) exp_fall++;
        m_scl = ns; m_sda = nd;
        scl_in = ns; sda_in = nd;
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic glitch(input bit on_sda, input int len);
        @(negedge clk);
        if (on_sda) sda_in = ~m_sda; else scl_in = ~m_scl;
        repeat (len) @(negedge clk);
        sda_in = m_sda; scl_in = m_scl;
        repeat (thr_now() + 4) @(negedge clk);
    endtask

    task automatic compare_counts(input string tag);
        check(mon_start == exp_start, {tag, " R4 start count"}, mon_start, exp_start);
        check(mon_stop  == exp_stop,  {tag, " R5 stop count"},  mon_stop,  exp_stop);
        check(mon_rise  == exp_rise,  {tag, " R6 rise count"},  mon_rise,  exp_rise);
        check(mon_fall  == exp_fall,  {tag, " R6 fall count"},  mon_fall,  exp_fall);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        scl_in = 1; sda_in = 1; tx_sda = 1; fast_mode = 0;
        filt_std_cyc = FILT_W'(STD_T); filt_fast_cyc = FILT_W'(FAST_T);
        rst_n = 0;
        repeat (5) @(negedge clk);
        check(scl_lvl && sda_lvl && bus_idle, "R1 levels in reset", {scl_lvl, sda_lvl, bus_idle}, 7);
        check(!(scl_rise | scl_fall | start_det | stop_det) && !sda_drive_low,
              "R1 strobes in reset", {scl_rise, scl_fall, start_det, stop_det, sda_drive_low}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check(scl_lvl && sda_lvl && bus_idle && !sda_drive_low, "R1 after release",
              {scl_lvl, sda_lvl, bus_idle, sda_drive_low}, 14);

        // R2: threshold boundary on SCL and SDA
        glitch(0, STD_T - 1);
        check(mon_fall == 0, "R2 short SCL pulse rejected", mon_fall, 0);
        glitch(0, STD_T);
        exp_fall++; exp_rise++;
        check(mon_fall == 1 && mon_rise == 1, "R2 full SCL pulse accepted", mon_fall + mon_rise, 2);
        glitch(1, STD_T - 1);
        check(mon_start == 0, "R2 short SDA pulse rejected", mon_start, 0);

        // R3: fast threshold and zero threshold
        fast_mode = 1;
        glitch(0, FAST_T - 1);
        check(mon_fall == exp_fall, "R3 fast short pulse rejected", mon_fall, exp_fall);
        glitch(0, FAST_T);
        exp_fall++; exp_rise++;
        check(mon_fall == exp_fall, "R3 fast threshold accepted", mon_fall, exp_fall);
        filt_fast_cyc = '0;
        glitch(0, 1);
        exp_fall++; exp_rise++;
        check(mon_fall == exp_fall, "R3 zero threshold acts as one", mon_fall, exp_fall);
        filt_fast_cyc = FILT_W'(FAST_T);
        fast_mode = 0;

        // R4, R8: start
        move(1, 0, STD_T + 4);
        check(mon_start == exp_start && exp_start == 1, "R4 start seen", mon_start, 1);
        check(bus_idle == 0, "R8 busy after start", bus_idle, 0);
        // R6: data bits
        move(0, 0, STD_T + 4); move(0, 1, STD_T + 4); move(1, 1, STD_T + 4);
        move(0, 1, STD_T + 4); move(0, 0, STD_T + 4); move(1, 0, STD_T + 4);
        compare_counts("bits");
        check(width_err == 0, "R6 one-cycle strobes", width_err, 0);
        // R5, R8: stop
        move(1, 1, STD_T + 4);
        check(mon_stop == 1, "R5 stop seen", mon_stop, 1);
        check(bus_idle == 1, "R8 idle after stop", bus_idle, 1);
        // R7: simultaneous changes
        move(1, 0, STD_T + 4);
        move(0, 1, STD_T + 4);
        move(1, 0, STD_T + 4);
        compare_counts("R7 simultaneous");
        check(excl_err == 0, "R7 strobes exclusive", excl_err, 0);

        // R10 then R9
        @(negedge clk); tx_sda = 0;
        repeat (50) @(negedge clk);
        check(sda_drive_low == 0, "R10 held while SCL high", sda_drive_low, 0);
        move(0, 0, HOLD_CYC + STD_T + 12);
        check(sda_drive_low == 1, "R9 request applied", sda_drive_low, 1);
        check(last_delay == HOLD_CYC + 2, "R9 hold delay", last_delay, HOLD_CYC + 2);
        @(negedge clk); tx_sda = 1;
        repeat (3) @(negedge clk);
        check(sda_drive_low == 0, "R9 release after window", sda_drive_low, 0);
        move(1, 0, STD_T + 4);
        @(negedge clk); tx_sda = 0;
        repeat (40) @(negedge clk);
        check(sda_drive_low == 0, "R10 frozen second case", sda_drive_low, 0);
        @(negedge clk); tx_sda = 1;

        // constrained random phase
        void'($urandom(32'd7351));
        for (int i = 0; i < 300; i++) begin
            int r;
            if (i % 60 == 0) fast_mode = logic'($urandom % 2);
            r = int'($urandom % 4);
            case (r)
                0: move(logic'($urandom % 2), logic'($urandom % 2),
                        thr_now() + 3 + int'($urandom % 40));
                1: glitch(0, 1 + int'($urandom % (thr_now() - 1)));
                2: glitch(1, 1 + int'($urandom % (thr_now() - 1)));
                default: begin
                    @(negedge clk); tx_sda = logic'($urandom % 2);
                end
            endcase
            if (r == 0)
                check(bus_idle == (m_scl && m_sda), "R8 idle tracks levels",
                      bus_idle, int'(m_scl && m_sda));
        end
        repeat (20) @(negedge clk);
        compare_counts("random");
        check(width_err == 0, "R6 random strobe width", width_err, 0);
        check(excl_err == 0, "R7 random exclusivity", excl_err, 0);
        finish_run();
    end
endmodule